// File: doc/BRIEF.md
# Serial Character Transmitter with Line Preamble

This block turns parallel characters into an asynchronous serial stream. Software, or a neighbouring block, writes a byte into a single holding register. It can also supply a ninth bit. The block moves that entry into a shift register and clocks it out one bit per pulse of an external bit-rate enable. Each character is framed by a low start bit and a high stop bit. The ninth bit, when the wide format is selected, goes between the last data bit and the stop bit.

Whenever the enable input goes from low to high, the block queues one character time of continuous marking level. This preamble lets a far receiver synchronise before real data arrives. A break request sends a whole character time of space level. The request is latched, so a single-cycle pulse still produces one break. A held request produces back-to-back breaks.

When the enable is dropped, the block keeps driving the line until every queued item has left the shift register. Those items are the preamble, a break, the character in the shift register and the character in the holding register. Only then does it release the line. Two status flags report state, each with its own interrupt mask: one says the holding register is free, and one says everything has gone quiet.

Top module: `async_tx`

## Requirements
- R1: After reset the line output is 1, the drive-enable output is 0, both the holding-empty and the done flags are 1, and the interrupt request is 0.
- R2: A character in the narrow format occupies exactly 10 bit periods on the line. The periods are a 0 start bit, then the 8 data bits least-significant first, then a 1 stop bit. The line changes only on cycles that follow a bit-rate enable pulse.
- R3: When the wide-format input is 1 at load time, the ninth bit is sent after data bit 7 and before the stop bit, for a total of 11 bit periods.
- R4: A 0-to-1 transition of the enable queues an all-ones preamble 10 bit periods long, or 11 in the wide format. The preamble is sent ahead of any waiting character.
- R5: A write to the holding register clears the holding-empty flag. The flag returns to 1 only when the held character is moved into the shift register. A character written while another one is shifting starts immediately after that character's stop bit.
- R6: The done flag is 1 only when the shift register is idle, the holding register is empty, and no preamble or break is pending. A write clears it, and while it is 1 the line stays at 1.
- R7: A rising edge on the break request, even one cycle long, sends one full character time of 0s, including the stop position. While the request stays high, further breaks follow with no gap.
- R8: While the enable is 1, the drive-enable output is 1. After the enable falls, drive-enable stays 1 until the last queued item has been shifted out, and then goes to 0.
- R9: Raising the enable again while the last character is still shifting queues a preamble after that character. Drive-enable does not drop.
- R10: The interrupt request is 1 exactly when the holding-empty flag is 1 with its mask set, or the done flag is 1 with its mask set.
- R11: While the line is not owned, the line output reads 1. A character written while the transmitter is disabled and not owning the line waits in the holding register and is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | DATA_W | Character written to the holding register |
| wr_ninth | input | 1 | Ninth bit written with the character |
| tx_enable | input | 1 | Transmitter enable |
| send_break | input | 1 | Break request |
| fmt_9bit | input | 1 | 1 selects the format with a ninth bit |
| empty_ie | input | 1 | Interrupt mask for the holding-empty flag |
| done_ie | input | 1 | Interrupt mask for the done flag |
| line_out | output | 1 | Serial line level |
| line_oe | output | 1 | 1 while the block owns and drives the line |
| hold_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Nothing shifting or pending |
| tx_irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default parameters: 8-bit characters and a two-stage reset synchroniser. It pulses the bit-rate enable every fourth clock, so a 10- or 11-period frame lasts only 40 to 44 cycles. That makes several scenarios cheap to run: back-to-back characters, three consecutive breaks, the drop of the enable partway through the preamble, and re-enabling during a character. The bench records the line and the drive-enable once per bit period, so it can count preamble and break lengths exactly and decode whole frames from the record.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  // What the sequencer hands to the shift register on a load slot
  typedef enum logic [1:0] {
    LOAD_NONE  = 2'd0,
    LOAD_IDLE  = 2'd1,
    LOAD_BREAK = 2'd2,
    LOAD_DATA  = 2'd3
  } load_kind_e;

endpackage

// File: rtl/async_tx_holdreg.sv
module async_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_ninth
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ninth_q, ninth_d;

  // Next state: a write wins over a same-cycle transfer to the shifter
  always_comb begin
    full_d  = full_q;
    data_d  = data_q;
    ninth_d = ninth_q;
    if (take) begin
      full_d = 1'b0;
    end
    if (wr_en) begin
      full_d  = 1'b1;
      data_d  = wr_data;
      ninth_d = wr_ninth;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      ninth_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      data_q  <= data_d;
      ninth_q <= ninth_d;
    end
  end

  assign hold_full  = full_q;
  assign hold_data  = data_q;
  assign hold_ninth = ninth_q;

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_enable,
  input  logic       send_break,
  input  logic       hold_full,
  input  logic       sh_busy,
  input  logic       sh_last,
  output logic       owned,
  output logic       load,
  output load_kind_e load_kind,
  output logic       take,
  output logic       quiet
);

  logic en_q, en_d;
  logic sb_q, sb_d;
  logic pre_q, pre_d;
  logic brk_q, brk_d;
  logic own_q, own_d;

  logic en_rise;
  logic sb_rise;
  logic brk_req;
  logic slot;

  assign en_rise = tx_enable & ~en_q;
  assign sb_rise = send_break & ~sb_q;
  // A latched request, or a live request while the line is ours
  assign brk_req = brk_q | (send_break & own_q);
  // The shifter can take a new item at the end of its last bit or when idle
  assign slot    = bit_tick & own_q & (~sh_busy | sh_last);

  // Priority: preamble first, then break, then data
  always_comb begin
    load_kind = LOAD_NONE;
    if (slot) begin
      if (pre_q) begin
        load_kind = LOAD_IDLE;
      end else if (brk_req) begin
        load_kind = LOAD_BREAK;
      end else if (hold_full) begin
        load_kind = LOAD_DATA;
      end
    end
  end

  assign load = (load_kind != LOAD_NONE);
  assign take = (load_kind == LOAD_DATA);

  always_comb begin
    en_d  = tx_enable;
    sb_d  = send_break;
    pre_d = en_rise | (pre_q & (load_kind != LOAD_IDLE));
    brk_d = (brk_q | (sb_rise & (tx_enable | own_q))) & (load_kind != LOAD_BREAK);
    own_d = tx_enable | (own_q & (sh_busy | hold_full | brk_req | pre_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sb_q  <= 1'b0;
      pre_q <= 1'b0;
      brk_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      sb_q  <= sb_d;
      pre_q <= pre_d;
      brk_q <= brk_d;
      own_q <= own_d;
    end
  end

  assign owned = own_q;
  assign quiet = ~sh_busy & ~hold_full & ~pre_q & ~brk_req;

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load,
  input  load_kind_e        load_kind,
  input  logic              fmt_9bit,
  input  logic [DATA_W-1:0] data,
  input  logic              ninth,
  output logic              busy,
  output logic              last,
  output logic              ser_bit
);

  // start + data + ninth + stop
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;

  // Frame image, bit 0 leaves first
  always_comb begin
    frame_len = fmt_9bit ? LEN_WIDE : LEN_NARROW;
    case (load_kind)
      LOAD_IDLE:  frame = '1;
      LOAD_BREAK: frame = '0;
      LOAD_DATA: begin
        if (fmt_9bit) begin
          frame = {1'b1, ninth, data, 1'b0};
        end else begin
          frame = {2'b11, data, 1'b0};
        end
      end
      default:    frame = '1;
    endcase
  end

  assign last = busy_q & (cnt_q == CNT_ONE);

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (bit_tick) begin
      if (load) begin
        sr_d   = frame;
        cnt_d  = frame_len;
        busy_d = 1'b1;
      end else if (busy_q) begin
        if (last) begin
          busy_d = 1'b0;
          cnt_d  = '0;
          sr_d   = '1;
        end else begin
          sr_d  = {1'b1, sr_q[FRAME_W-1:1]};
          cnt_d = cnt_q - CNT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign ser_bit = busy_q ? sr_q[0] : 1'b1;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              tx_enable,
  input  logic              send_break,
  input  logic              fmt_9bit,
  input  logic              empty_ie,
  input  logic              done_ie,
  output logic              line_out,
  output logic              line_oe,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              tx_irq
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  // Reset asserts at once, releases after SYNC_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_ninth;
  logic              take;
  logic              owned;
  logic              load;
  load_kind_e        load_kind;
  logic              quiet;
  logic              sh_busy;
  logic              sh_last;
  logic              ser_bit;

  async_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_ninth   (wr_ninth),
    .take       (take),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .hold_ninth (hold_ninth)
  );

  async_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bit_tick   (bit_tick),
    .tx_enable  (tx_enable),
    .send_break (send_break),
    .hold_full  (hold_full),
    .sh_busy    (sh_busy),
    .sh_last    (sh_last),
    .owned      (owned),
    .load       (load),
    .load_kind  (load_kind),
    .take       (take),
    .quiet      (quiet)
  );

  async_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bit_tick  (bit_tick),
    .load      (load),
    .load_kind (load_kind),
    .fmt_9bit  (fmt_9bit),
    .data      (hold_data),
    .ninth     (hold_ninth),
    .busy      (sh_busy),
    .last      (sh_last),
    .ser_bit   (ser_bit)
  );

  assign line_out   = ser_bit;
  assign line_oe    = owned;
  assign hold_empty = ~hold_full;
  assign tx_done    = quiet;
  assign tx_irq     = (hold_empty & empty_ie) | (quiet & done_ie);

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_en,
  input logic tx_enable,
  input logic send_break,
  input logic empty_ie,
  input logic done_ie,
  input logic line_out,
  input logic line_oe,
  input logic hold_empty,
  input logic tx_done,
  input logic tx_irq
);

  // R2
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(line_out));

  // R5
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  // R6
  wr_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_done);

  // R6
  done_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> line_out);

  // R7
  break_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_break && line_oe) |-> !tx_done);

  // R8
  enable_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |=> line_oe);

  // R10
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_ie && !done_ie) |-> !tx_irq);

  // R11
  unowned_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> line_out);

endmodule

bind async_tx async_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .bit_tick   (bit_tick),
  .wr_en      (wr_en),
  .tx_enable  (tx_enable),
  .send_break (send_break),
  .empty_ie   (empty_ie),
  .done_ie    (done_ie),
  .line_out   (line_out),
  .line_oe    (line_oe),
  .hold_empty (hold_empty),
  .tx_done    (tx_done),
  .tx_irq     (tx_irq)
);

// File: tb/test_async_tx.sv
module test_async_tx;

  localparam int DW    = 8;
  localparam int LOG_N = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ninth = 1'b0;
  logic          tx_enable = 1'b0;
  logic          send_break = 1'b0;
  logic          fmt_9bit = 1'b0;
  logic          empty_ie = 1'b0;
  logic          done_ie = 1'b0;
  logic          line_out, line_oe, hold_empty, tx_done, tx_irq;

  always #2 clk = ~clk;

  async_tx #(.DATA_W(DW)) i_async_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_ninth(wr_ninth), .tx_enable(tx_enable),
    .send_break(send_break), .fmt_9bit(fmt_9bit), .empty_ie(empty_ie),
    .done_ie(done_ie), .line_out(line_out), .line_oe(line_oe),
    .hold_empty(hold_empty), .tx_done(tx_done), .tx_irq(tx_irq)
  );

  int   n_tests = 0;
  int   n_fails = 0;
  int   tick_cnt = 0;
  int   log_n = 0;
  logic log_line [0:LOG_N-1];
  logic log_oe   [0:LOG_N-1];

  // Bit-rate pulse every 4 clocks; the line is logged once per bit period
  always @(negedge clk) begin
    if (tick_cnt == 0) begin
      if (rst_n && log_n < LOG_N) begin
        log_line[log_n] = line_out;
        log_oe[log_n]   = line_oe;
        log_n++;
      end
      bit_tick = 1'b1;
    end else begin
      bit_tick = 1'b0;
    end
    tick_cnt = (tick_cnt + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic sync_tick();
    do step(); while (!bit_tick);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) sync_tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_ninth = 1'b0;
    tx_enable = 1'b0; send_break = 1'b0; fmt_9bit = 1'b0;
    empty_ie = 1'b0; done_ie = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    log_n = 0;
  endtask

  function automatic int first_oe();
    for (int i = 0; i < log_n; i++) if (log_oe[i]) return i;
    return 0;
  endfunction

  function automatic int first_zero(input int from);
    for (int i = from; i < log_n; i++) if (log_line[i] == 1'b0) return i;
    return from;
  endfunction

  function automatic int run_of(input int from, input logic v);
    int n = 0;
    for (int i = from; i < log_n; i++) begin
      if (log_line[i] !== v) return n;
      n++;
    end
    return n;
  endfunction

  function automatic int byte_at(input int i);
    int v = 0;
    for (int k = 0; k < 8; k++) if (log_line[i + 1 + k] === 1'b1) v |= (1 << k);
    return v;
  endfunction

  function automatic bit frame_ok(input int i, input int d, input bit nine, input bit b8);
    int stop_i;
    bit ok;
    ok = 1'b1;
    stop_i = nine ? i + 10 : i + 9;
    if (log_line[i] !== 1'b0) ok = 1'b0;
    if (byte_at(i) != d) ok = 1'b0;
    if (nine && log_line[i + 9] !== b8) ok = 1'b0;
    if (log_line[stop_i] !== 1'b1) ok = 1'b0;
    for (int k = i; k <= stop_i; k++) if (log_oe[k] !== 1'b1) ok = 1'b0;
    return ok;
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk(line_out === 1'b1, "R1 line", line_out, 1);
    chk(line_oe === 1'b0, "R1 oe", line_oe, 0);
    chk(hold_empty === 1'b1, "R1 empty", hold_empty, 1);
    chk(tx_done === 1'b1, "R1 done", tx_done, 1);
    chk(tx_irq === 1'b0, "R1 irq", tx_irq, 0);
  endtask

  task automatic t_frame_narrow();
    int i0;
    do_reset();
    sync_tick();
    tx_enable = 1'b1; wr_data = 8'hA5; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    chk(hold_empty === 1'b0, "R5 write clears empty", hold_empty, 0);
    wait_ticks(5);
    chk(hold_empty === 1'b0, "R5 held during preamble", hold_empty, 0);
    wait_ticks(7);
    chk(hold_empty === 1'b1, "R5 set on transfer", hold_empty, 1);
    chk(tx_done === 1'b0, "R6 busy not done", tx_done, 0);
    wait_ticks(11);
    chk(tx_done === 1'b1, "R6 done when quiet", tx_done, 1);
    i0 = first_oe();
    chk(run_of(i0, 1'b1) == 11, "R4 narrow preamble", run_of(i0, 1'b1), 11);
    chk(frame_ok(i0 + 11, 'hA5, 1'b0, 1'b0), "R2 narrow frame", byte_at(i0 + 11), 'hA5);
  endtask

  task automatic t_frame_wide();
    int i0;
    do_reset();
    fmt_9bit = 1'b1;
    sync_tick();
    tx_enable = 1'b1; wr_data = 8'h3C; wr_ninth = 1'b1; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(30);
    i0 = first_oe();
    chk(run_of(i0, 1'b1) == 12, "R4 wide preamble", run_of(i0, 1'b1), 12);
    chk(frame_ok(i0 + 12, 'h3C, 1'b1, 1'b1), "R3 wide frame", byte_at(i0 + 12), 'h3C);
    chk(log_line[i0 + 21] === 1'b1, "R3 ninth bit", log_line[i0 + 21], 1);
  endtask

  task automatic t_back_to_back();
    int i0;
    do_reset();
    sync_tick();
    tx_enable = 1'b1; wr_data = 8'h5A; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(12);
    wr_data = 8'hC3; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(25);
    i0 = first_oe();
    chk(frame_ok(i0 + 11, 'h5A, 1'b0, 1'b0), "R5 first frame", byte_at(i0 + 11), 'h5A);
    chk(frame_ok(i0 + 21, 'hC3, 1'b0, 1'b0), "R5 second frame no gap", byte_at(i0 + 21), 'hC3);
  endtask

  task automatic t_break();
    int mark, z;
    do_reset();
    sync_tick();
    tx_enable = 1'b1;
    wait_ticks(15);
    mark = log_n;
    send_break = 1'b1;
    step();
    send_break = 1'b0;
    chk(tx_done === 1'b0, "R7 break pending blocks done", tx_done, 0);
    wait_ticks(15);
    z = first_zero(mark);
    chk(run_of(z, 1'b0) == 10, "R7 pulsed break length", run_of(z, 1'b0), 10);
    mark = log_n;
    send_break = 1'b1;
    wait_ticks(25);
    send_break = 1'b0;
    wait_ticks(15);
    z = first_zero(mark);
    chk(run_of(z, 1'b0) == 30, "R7 held break repeats", run_of(z, 1'b0), 30);
    chk(line_out === 1'b1, "R7 line back high", line_out, 1);
  endtask

  task automatic t_disable_release();
    int i0;
    do_reset();
    sync_tick();
    tx_enable = 1'b1; wr_data = 8'h81; wr_en = 1'b1;
    step();
    wr_en = 1'b0; tx_enable = 1'b0;
    wait_ticks(30);
    i0 = first_oe();
    chk(frame_ok(i0 + 11, 'h81, 1'b0, 1'b0), "R8 pending char sent", byte_at(i0 + 11), 'h81);
    chk(log_oe[i0 + 21] === 1'b0, "R8 release after stop", log_oe[i0 + 21], 0);
    chk(line_oe === 1'b0, "R8 released", line_oe, 0);
    chk(line_out === 1'b1, "R11 unowned high", line_out, 1);
  endtask

  task automatic t_reenable();
    int i0, lost;
    do_reset();
    sync_tick();
    tx_enable = 1'b1; wr_data = 8'h42; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(12);
    tx_enable = 1'b0;
    step(); step();
    tx_enable = 1'b1; wr_data = 8'h99; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(35);
    i0 = first_oe();
    chk(frame_ok(i0 + 11, 'h42, 1'b0, 1'b0), "R9 last char", byte_at(i0 + 11), 'h42);
    chk(run_of(i0 + 20, 1'b1) == 11, "R9 preamble after char", run_of(i0 + 20, 1'b1), 11);
    chk(frame_ok(i0 + 31, 'h99, 1'b0, 1'b0), "R9 next char", byte_at(i0 + 31), 'h99);
    lost = 0;
    for (int k = i0; k < i0 + 41; k++) if (log_oe[k] !== 1'b1) lost++;
    chk(lost == 0, "R9 ownership kept", lost, 0);
  endtask

  task automatic t_irq();
    do_reset();
    empty_ie = 1'b1;
    step();
    chk(tx_irq === 1'b1, "R10 empty irq", tx_irq, 1);
    tx_enable = 1'b1; wr_data = 8'h0F; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    chk(tx_irq === 1'b0, "R10 empty cleared", tx_irq, 0);
    empty_ie = 1'b0; done_ie = 1'b1;
    step();
    chk(tx_irq === 1'b0, "R10 done not yet", tx_irq, 0);
    wait_ticks(30);
    chk(tx_irq === 1'b1, "R10 done irq", tx_irq, 1);
    done_ie = 1'b0;
    step();
    chk(tx_irq === 1'b0, "R10 masked", tx_irq, 0);
  endtask

  task automatic t_held_while_disabled();
    int i0, bad;
    do_reset();
    wr_data = 8'h66; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    wait_ticks(15);
    bad = 0;
    for (int k = 0; k < log_n; k++) if (log_oe[k] !== 1'b0 || log_line[k] !== 1'b1) bad++;
    chk(bad == 0, "R11 nothing sent while disabled", bad, 0);
    chk(hold_empty === 1'b0, "R11 char still held", hold_empty, 0);
    chk(tx_done === 1'b0, "R6 held char blocks done", tx_done, 0);
    sync_tick();
    tx_enable = 1'b1;
    wait_ticks(30);
    i0 = first_oe();
    chk(run_of(i0, 1'b1) == 11, "R4 preamble before held char", run_of(i0, 1'b1), 11);
    chk(frame_ok(i0 + 11, 'h66, 1'b0, 1'b0), "R11 held char sent on enable", byte_at(i0 + 11), 'h66);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_frame_narrow();
    t_frame_wide();
    t_back_to_back();
    t_break();
    t_disable_release();
    t_reenable();
    t_irq();
    t_held_while_disabled();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule